// File: doc/BRIEF.md
# Dual-Mode Preloadable Down-Counter/Timer

This block is a 16-bit down-counter that the CPU loads through two byte-wide preload registers, one for the upper byte and one for the lower byte. A two-bit field in a control byte selects the count clock. There are four choices: the channel A transmit clock, the channel B transmit clock, a crystal clock divided by a parameter (16 by default), or an external pin. Every source is sampled into the system clock domain. Each rising edge of the selected source produces one count step.

The block has two modes. In timer mode, which is the mode after reset, it runs without stopping. On each terminal count it reloads the preload value and toggles its output pin, so the pin carries a square wave whose period is twice the preload, counted in source edges. The CPU can only clear the ready flag in this mode. In counter mode the CPU starts the count with a start strobe, which also loads the preload value. It halts the count with a stop strobe. The count can be read only while the counter is halted. This makes the block usable as a stopwatch, a one-shot event generator or a watchdog. On the step from 1 to 0 the block raises a ready flag. The count then wraps to 0xFFFF and keeps going until it is stopped.

Top module: `ct_down_timer`

## Requirements
- R1: After reset the block is in timer mode with source 0 selected. The count and the preload both equal the PRESET parameter. `ready` is 0, `ct_pin` is 0 and `count_rd` is 0.
- R2: `wr_hi`/`wr_lo` store `wdata` into the upper/lower preload byte. A rewrite does not disturb a running count and is taken at the next load.
- R3: Control byte bits [1:0] select the source: 0 = `src_cha`, 1 = `src_chb`, 2 = `src_xtal` divided by XTAL_DIV, 3 = `src_ext`. Each rising edge of the selected source, after synchronization, is one step. Edges on the other sources have no effect.
- R4: In timer mode, a step taken when the count is 1 (or 0) reloads the preload, toggles the timer output and sets `ready`. Other steps decrement the count, so `ct_pin` toggles every P steps.
- R5: In timer mode counting never halts. `start_stb` has no effect, and `stop_stb` only clears `ready`.
- R6: Control byte bit 2 = 1 selects counter mode. Entering counter mode halts counting and keeps the current count. `start_stb` loads the preload and starts counting.
- R7: In counter mode, the step from 1 to 0 sets `ready`. The next step wraps the count to 0xFFFF, and counting continues until stopped.
- R8: `stop_stb` clears `ready`. In counter mode it also halts counting, and steps while halted have no effect. A terminal step in the same cycle wins over the clear.
- R9: `count_rd` shows the count while the block is in counter mode and halted. Otherwise it reads 0.
- R10: In counter mode `ct_pin` follows `ready`. In timer mode it shows the toggling output.
- R11: Writing the control byte with bit 2 = 0 enters timer mode. It reloads the preload and starts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_cha | input | 1 | Channel A transmit clock source |
| src_chb | input | 1 | Channel B transmit clock source |
| src_xtal | input | 1 | Crystal clock, divided inside the block |
| src_ext | input | 1 | External count pin |
| wdata | input | 8 | Write data for the register strobes |
| wr_hi | input | 1 | Write strobe, upper preload byte |
| wr_lo | input | 1 | Write strobe, lower preload byte |
| wr_ctl | input | 1 | Write strobe, control byte (bit 2 mode, bits 1:0 source) |
| start_stb | input | 1 | Start command strobe |
| stop_stb | input | 1 | Stop command strobe / ready clear |
| count_rd | output | 16 | Count readback, valid while halted in counter mode |
| ready | output | 1 | Terminal-count ready flag |
| ct_pin | output | 1 | Output pin drive |

## Verification
The bench sets XTAL_DIV to 4 and PRESET to 3. Because PRESET is 3, the timer output toggles after only three source edges following reset, so the timer waveform and its period can be checked before any register is written. Because XTAL_DIV is 4, a handful of crystal edges is enough to confirm that the divided path produces exactly one step per four edges. With SYNC_STAGES at its default of 2, each source pulse lasts a few system clocks, so every step settles well before the bench samples the outputs.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned CT_W = 16;

  typedef enum logic [1:0] {
    SRC_CHA  = 2'd0,
    SRC_CHB  = 2'd1,
    SRC_XTAL = 2'd2,
    SRC_EXT  = 2'd3
  } ct_src_e;

  // terminal condition: timer reloads on 1 (or a stray 0), counter flags 1->0 only
  function automatic logic ct_is_terminal(input logic [CT_W-1:0] c, input logic timer);
    if (timer) return (c <= CT_W'(1));
    return (c == CT_W'(1));
  endfunction

  // value after one step
  function automatic logic [CT_W-1:0] ct_step(input logic [CT_W-1:0] c,
                                              input logic [CT_W-1:0] pl,
                                              input logic timer);
    if (timer && c <= CT_W'(1)) return pl;
    return c - CT_W'(1);
  endfunction
endpackage

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned LEN = STAGES + 1;
  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LEN-2:0], async_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ct_prescale.sv
module ct_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pulse,
  output logic out_pulse
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (in_pulse) div_q <= (div_q == LAST) ? '0 : div_q + PW'(1);
  end

  assign out_pulse = in_pulse && (div_q == LAST);
endmodule

// File: rtl/ct_core.sv
module ct_core
  import ct_pkg::*;
#(
  parameter logic [CT_W-1:0] PRESET = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            start_stb,
  input  logic            stop_stb,
  input  logic            ctl_wr,
  input  logic            ctl_cnt_mode,
  input  logic [CT_W-1:0] preload,
  output logic [CT_W-1:0] count,
  output logic            cnt_mode,
  output logic            running,
  output logic            ready,
  output logic            wave,
  output logic            step_evt,
  output logic            tc_evt,
  output logic            load_evt
);
  logic [CT_W-1:0] cnt_q;
  logic            mode_q, run_q, rdy_q, wave_q;
  logic            cmd_start, cmd_stop;

  // commands only act in counter mode and only when no control write competes
  assign cmd_stop  = !ctl_wr && mode_q && stop_stb;
  assign cmd_start = !ctl_wr && mode_q && start_stb && !stop_stb;
  assign load_evt  = (ctl_wr && !ctl_cnt_mode) || cmd_start;
  assign step_evt  = tick && run_q && !ctl_wr && !(mode_q && (start_stb || stop_stb));
  assign tc_evt    = step_evt && ct_is_terminal(cnt_q, !mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= PRESET;
      mode_q <= 1'b0;
      run_q  <= 1'b1;
      rdy_q  <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        mode_q <= ctl_cnt_mode;
        run_q  <= !ctl_cnt_mode;
      end else if (cmd_stop) begin
        run_q <= 1'b0;
      end else if (cmd_start) begin
        run_q <= 1'b1;
      end

      if (load_evt)      cnt_q <= preload;
      else if (step_evt) cnt_q <= ct_step(cnt_q, preload, !mode_q);

      if (tc_evt)        rdy_q <= 1'b1;
      else if (stop_stb) rdy_q <= 1'b0;

      if (tc_evt && !mode_q) wave_q <= ~wave_q;
    end
  end

  assign count    = cnt_q;
  assign cnt_mode = mode_q;
  assign running  = run_q;
  assign ready    = rdy_q;
  assign wave     = wave_q;
endmodule

// File: rtl/ct_down_timer.sv
module ct_down_timer
  import ct_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      XTAL_DIV    = 16,
  parameter logic [CT_W-1:0]  PRESET      = 16'hFFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_cha,
  input  logic            src_chb,
  input  logic            src_xtal,
  input  logic            src_ext,
  input  logic [7:0]      wdata,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic            wr_ctl,
  input  logic            start_stb,
  input  logic            stop_stb,
  output logic [CT_W-1:0] count_rd,
  output logic            ready,
  output logic            ct_pin
);
  localparam int unsigned BYTE_W = CT_W / 2;
  localparam int unsigned NSRC   = 4;

  // preload byte registers and source select
  logic [BYTE_W-1:0] pl_hi_q, pl_lo_q;
  ct_src_e           src_q;
  logic [CT_W-1:0]   preload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_hi_q <= PRESET[CT_W-1:BYTE_W];
      pl_lo_q <= PRESET[BYTE_W-1:0];
      src_q   <= SRC_CHA;
    end else begin
      if (wr_hi)  pl_hi_q <= wdata;
      if (wr_lo)  pl_lo_q <= wdata;
      if (wr_ctl) src_q   <= ct_src_e'(wdata[1:0]);
    end
  end
  assign preload = {pl_hi_q, pl_lo_q};

  // synchronized rising edges of every source
  logic [NSRC-1:0] raw_src, src_rise, src_tick;
  assign raw_src = {src_ext, src_xtal, src_chb, src_cha};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(raw_src[g]),
      .rise    (src_rise[g])
    );
    if (g == int'(SRC_XTAL)) begin : g_div
      ct_prescale #(.DIV(XTAL_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_pulse (src_rise[g]),
        .out_pulse(src_tick[g])
      );
    end else begin : g_direct
      assign src_tick[g] = src_rise[g];
    end
  end

  logic tick_sel;
  assign tick_sel = src_tick[src_q];

  // count engine
  logic [CT_W-1:0] count;
  logic cnt_mode, running, wave, step_evt, tc_evt, load_evt, rdy;

  ct_core #(.PRESET(PRESET)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_sel),
    .start_stb   (start_stb),
    .stop_stb    (stop_stb),
    .ctl_wr      (wr_ctl),
    .ctl_cnt_mode(wdata[2]),
    .preload     (preload),
    .count       (count),
    .cnt_mode    (cnt_mode),
    .running     (running),
    .ready       (rdy),
    .wave        (wave),
    .step_evt    (step_evt),
    .tc_evt      (tc_evt),
    .load_evt    (load_evt)
  );

  assign count_rd = (cnt_mode && !running) ? count : '0;
  assign ready    = rdy;
  assign ct_pin   = cnt_mode ? rdy : wave;
endmodule

// File: rtl/ct_down_timer_chk.sv
module ct_down_timer_chk
  import ct_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            stop_stb,
  input logic            cnt_mode,
  input logic            running,
  input logic            step_evt,
  input logic            tc_evt,
  input logic            load_evt,
  input logic            wr_ctl,
  input logic            wave,
  input logic            ready,
  input logic [CT_W-1:0] count,
  input logic [CT_W-1:0] preload
);
  // R7 / R4: a terminal step raises the flag
  p_ready_on_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> ready);

  // R8: stop clears the flag unless a terminal step coincides
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb && !tc_evt) |=> !ready);

  // R5: timer mode never halts
  p_timer_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_mode |-> running);

  // R6 / R8: without a step or load the count holds
  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !load_evt) |=> $stable(count));

  // R2: a load takes the preload value
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (count == $past(preload)));

  // R4: the timer output changes only on a terminal step
  p_wave_only_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_evt |=> $stable(wave));

  // R7: counter mode wraps after zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && cnt_mode && count == '0 && !wr_ctl) |=> (count == '1));
endmodule

bind ct_down_timer ct_down_timer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stop_stb(stop_stb),
  .cnt_mode(cnt_mode),
  .running (running),
  .step_evt(step_evt),
  .tc_evt  (tc_evt),
  .load_evt(load_evt),
  .wr_ctl  (wr_ctl),
  .wave    (wave),
  .ready   (rdy),
  .count   (count),
  .preload (preload)
);

// File: tb/test_ct_down_timer.sv
module test_ct_down_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_cha = 0, src_chb = 0, src_xtal = 0, src_ext = 0;
  logic [7:0] wdata = '0;
  logic wr_hi = 0, wr_lo = 0, wr_ctl = 0, start_stb = 0, stop_stb = 0;
  logic [15:0] count_rd;
  logic ready, ct_pin;

  always #5 clk = ~clk;

  ct_down_timer #(.SYNC_STAGES(2), .XTAL_DIV(4), .PRESET(16'd3)) i_ct_down_timer (
    .clk(clk), .rst_n(rst_n), .src_cha(src_cha), .src_chb(src_chb),
    .src_xtal(src_xtal), .src_ext(src_ext), .wdata(wdata), .wr_hi(wr_hi),
    .wr_lo(wr_lo), .wr_ctl(wr_ctl), .start_stb(start_stb), .stop_stb(stop_stb),
    .count_rd(count_rd), .ready(ready), .ct_pin(ct_pin)
  );

  typedef struct {
    int          kind;   // 0 count_rd, 1 ready, 2 ct_pin
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  // monitor: pops expectations and compares them with the outputs
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = count_rd;
          1:       act = {15'd0, ready};
          default: act = {15'd0, ct_pin};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int kind, input logic [15:0] v, input string tag);
    item_t it;
    it.kind = kind; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    @(posedge clk);
  endtask

  task automatic pulse(input int sel, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (sel) 0: src_cha = 1; 1: src_chb = 1; 2: src_xtal = 1; default: src_ext = 1; endcase
      repeat (3) @(negedge clk);
      src_cha = 0; src_chb = 0; src_xtal = 0; src_ext = 0;
      repeat (3) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe(input int which, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    case (which)
      0: wr_hi = 1; 1: wr_lo = 1; 2: wr_ctl = 1; 3: start_stb = 1; default: stop_stb = 1;
    endcase
    @(negedge clk);
    wr_hi = 0; wr_lo = 0; wr_ctl = 0; start_stb = 0; stop_stb = 0;
    repeat (2) @(negedge clk);
  endtask

  localparam int HI = 0, LO = 1, CTL = 2, START = 3, STOP = 4;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    expect_val(1, 0, "R1 ready after reset");
    expect_val(2, 0, "R1 pin after reset");
    expect_val(0, 0, "R1 count_rd after reset");

    pulse(0, 3);
    expect_val(2, 1, "R4 timer toggles after preset steps");
    expect_val(1, 1, "R4 terminal sets ready");
    strobe(STOP, 0);
    expect_val(1, 0, "R5 stop clears ready in timer mode");
    pulse(0, 3);
    expect_val(2, 0, "R4 second toggle after preset steps");
    strobe(START, 0);
    pulse(0, 2);
    expect_val(2, 0, "R5 start ignored in timer mode");
    pulse(0, 1);
    expect_val(2, 1, "R5 count unaffected by start");
    pulse(1, 3);
    expect_val(2, 1, "R3 unselected source ignored");

    strobe(HI, 8'h00);
    strobe(LO, 8'h05);
    strobe(CTL, 8'b101);
    expect_val(0, 16'd3, "R6 entering counter mode keeps count");
    expect_val(2, 1, "R10 pin follows ready in counter mode");
    strobe(STOP, 0);
    expect_val(1, 0, "R8 stop clears ready");
    expect_val(2, 0, "R10 pin low after clear");

    strobe(START, 0);
    expect_val(0, 0, "R9 count_rd zero while running");
    pulse(0, 2);
    pulse(1, 2);
    strobe(STOP, 0);
    expect_val(0, 16'd3, "R3 only channel B steps");
    pulse(1, 2);
    expect_val(0, 16'd3, "R8 halted count holds");

    strobe(START, 0);
    pulse(1, 5);
    expect_val(1, 1, "R7 ready at terminal count");
    expect_val(2, 1, "R10 pin high with ready");
    pulse(1, 1);
    strobe(STOP, 0);
    expect_val(0, 16'hFFFF, "R7 wrap past zero");
    expect_val(1, 0, "R8 stop clears ready after wrap");

    strobe(CTL, 8'b110);
    strobe(START, 0);
    pulse(2, 8);
    strobe(STOP, 0);
    expect_val(0, 16'd3, "R3 crystal divided by XTAL_DIV");

    strobe(CTL, 8'b111);
    strobe(START, 0);
    pulse(3, 1);
    strobe(STOP, 0);
    expect_val(0, 16'd4, "R3 external pin source");

    strobe(START, 0);
    pulse(3, 1);
    strobe(LO, 8'h09);
    pulse(3, 1);
    strobe(STOP, 0);
    expect_val(0, 16'd3, "R2 preload rewrite leaves running count");
    strobe(START, 0);
    strobe(STOP, 0);
    expect_val(0, 16'd9, "R2 new preload taken at load");

    strobe(CTL, 8'b011);
    expect_val(0, 0, "R11 timer mode hides count");
    expect_val(2, 1, "R11 pin shows timer output");
    pulse(3, 8);
    expect_val(2, 1, "R11 reload gives full preload");
    pulse(3, 1);
    expect_val(2, 0, "R11 toggle after preload steps");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule